// File: doc/BRIEF.md
# Masked vectored interrupt controller

This block gathers a set of level-sensitive interrupt lines, gates them with a software-owned enable mask, and presents the result to a processor core as a request wire plus a vector bus. It does no hardware prioritisation. When exactly one enabled line is high, the vector identifies that line. When two or more are high together, the vector collapses to one fixed shared code, and the interrupt handler reads the masked status word to decide the order of service itself.

A small word-addressed register window lets software write the mask and read back the raw line levels and the masked status. Undefined offsets in the window read as zero and raise a one-cycle error strobe. Two non-maskable lines drive a separate request that ignores the mask. A single fatal-error line is passed through as a registered error indication and is not handled further.

Top module: `irq_vector_ctrl`

## Requirements
- R1: The raw status word (offset 0x04) holds, bit i, the level of interrupt line i sampled at the previous clock edge; bits at and above the line count read as zero.
- R2: The mask (offset 0x00) is read/write and resets to zero. The masked status word (offset 0x08) equals the raw status ANDed bitwise with the mask.
- R3: With no masked bit set, irq_req is low and irq_vec is 0x00.
- R4: With exactly one masked bit i set, irq_req is high and irq_vec is 0x31 + i.
- R5: With two or more masked bits set, irq_req is high and irq_vec is 0x30.
- R6: irq_req and irq_vec are registered: they change at the first clock edge after a line change or a mask write, and not before it.
- R7: Writes to the read-only offsets 0x04 and 0x08 leave the mask and both status words unchanged.
- R8: An access with bus_sel high to offset 0x0C, 0x10, any offset of 0x14 or above, or any address with bus_addr[1:0] not zero reads as zero and drives bus_err high in the same cycle; a write there has no effect. Defined, aligned offsets never drive bus_err.
- R9: nmi_req is the OR of the two non-maskable lines, registered one clock, and is unaffected by the mask.
- R10: fatal_err follows the fatal line, registered one clock.
- R11: While rst_n is low, irq_req, irq_vec, nmi_req and fatal_err are zero and the mask is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_lines | input | 30 | Level-sensitive maskable interrupt lines |
| nmi_lines | input | 2 | Non-maskable interrupt lines |
| fatal_line | input | 1 | Fatal-error line |
| bus_sel | input | 1 | Register window access strobe |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | 5 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_sel |
| bus_err | output | 1 | Undefined-offset strobe, same cycle as bus_sel |
| irq_req | output | 1 | Maskable interrupt request to the core |
| irq_vec | output | 8 | Interrupt vector to the core |
| nmi_req | output | 1 | Non-maskable interrupt request |
| fatal_err | output | 1 | Registered fatal-error indication |

## Verification
The hardest situation to reach is the boundary between the unique-vector and shared-vector cases for every pair of lines, including pairs where one line is high but masked off, since a wrong count or a wrong gate only shows for particular bit combinations. The bench sweeps every single line and every pair of lines under a full mask, then holds all lines high while walking a single-bit mask and a two-bit mask across the word, so each line's gate is exercised in isolation. The one-clock latency is checked by sampling the vector just after the stimulus edge and again after the next clock edge.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;

  // Word slots of the register window, decoded from the byte offset.
  typedef enum logic [1:0] {
    SLOT_MASK   = 2'd0,
    SLOT_RAW    = 2'd1,
    SLOT_MASKED = 2'd2,
    SLOT_NONE   = 2'd3
  } win_slot_e;

  // Word index of each defined slot (byte offset divided by four).
  localparam int unsigned IDX_MASK   = 0;
  localparam int unsigned IDX_RAW    = 1;
  localparam int unsigned IDX_MASKED = 2;

  // Vector codes driven to the core.
  localparam logic [7:0] VEC_SHARED = 8'h30;
  localparam logic [7:0] VEC_BASE   = 8'h31;

endpackage

// File: rtl/irq_reg_window.sv
module irq_reg_window
  import irq_vector_pkg::*;
#(
  parameter int unsigned N_LINES = 30,
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_err,
  output logic [N_LINES-1:0] mask_d,
  output logic [N_LINES-1:0] mask_q,
  output logic [N_LINES-1:0] raw_q
);

  localparam int unsigned IW = AW - 2;

  win_slot_e          slot;
  logic               aligned;
  logic [IW-1:0]      word_idx;
  logic               mask_en;
  logic [N_LINES-1:0] status_sel;

  // Address decode
  always_comb begin
    aligned  = (bus_addr[1:0] == 2'b00);
    word_idx = bus_addr[AW-1:2];
    if (!aligned)
      slot = SLOT_NONE;
    else if (word_idx == IW'(IDX_MASK))
      slot = SLOT_MASK;
    else if (word_idx == IW'(IDX_RAW))
      slot = SLOT_RAW;
    else if (word_idx == IW'(IDX_MASKED))
      slot = SLOT_MASKED;
    else
      slot = SLOT_NONE;
  end

  // Mask next state with explicit enable
  always_comb begin
    mask_en = bus_sel && bus_wr && (slot == SLOT_MASK);
    mask_d  = mask_en ? bus_wdata[N_LINES-1:0] : mask_q;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      raw_q  <= '0;
    end else begin
      raw_q <= irq_lines;
      if (mask_en)
        mask_q <= mask_d;
    end
  end

  // Read mux and error strobe
  always_comb begin
    unique case (slot)
      SLOT_MASK:   status_sel = mask_q;
      SLOT_RAW:    status_sel = raw_q;
      SLOT_MASKED: status_sel = raw_q & mask_q;
      default:     status_sel = '0;
    endcase
    bus_rdata              = '0;
    bus_rdata[N_LINES-1:0] = bus_sel ? status_sel : '0;
    bus_err                = bus_sel && (slot == SLOT_NONE);
  end

  generate
    if (N_LINES < DW) begin : g_pad
      logic wdata_hi_unused;
      assign wdata_hi_unused = ^bus_wdata[DW-1:N_LINES];
    end
  endgenerate

  // R8: a flagged access returns zero
  assert_err_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_rdata == '0));

  // R7 / R8: writes outside the mask slot leave the mask alone
  assert_ro_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_addr != '0)) |=> $stable(mask_q));

  // R2: a mask write lands one clock later
  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && (bus_addr == '0)) |=> (mask_q == $past(bus_wdata[N_LINES-1:0])));

endmodule

// File: rtl/irq_vec_encoder.sv
module irq_vec_encoder
  import irq_vector_pkg::*;
#(
  parameter int unsigned N_LINES = 30,
  parameter int unsigned VW      = 8
) (
  input  logic [N_LINES-1:0] active,
  output logic               req,
  output logic [VW-1:0]      vec
);

  localparam int unsigned IXW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  logic [1:0]     hits;
  logic [IXW-1:0] line_ix;

  // Saturating population count (0, 1, many) and position of a set bit
  always_comb begin
    hits    = 2'd0;
    line_ix = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (active[i]) begin
        if (hits != 2'd2)
          hits = hits + 2'd1;
        line_ix = IXW'(i);
      end
    end
  end

  always_comb begin
    req = (hits != 2'd0);
    unique case (hits)
      2'd0:    vec = '0;
      2'd1:    vec = VW'(VEC_BASE) + VW'(line_ix);
      default: vec = VW'(VEC_SHARED);
    endcase
  end

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_vector_pkg::*;
#(
  parameter int unsigned N_LINES = 30,
  parameter int unsigned N_NMI   = 2,
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 5,
  parameter int unsigned VW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic [N_NMI-1:0]   nmi_lines,
  input  logic               fatal_line,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_err,
  output logic               irq_req,
  output logic [VW-1:0]      irq_vec,
  output logic               nmi_req,
  output logic               fatal_err
);

  logic [N_LINES-1:0] mask_d;
  logic [N_LINES-1:0] mask_q;
  logic [N_LINES-1:0] raw_q;
  logic [N_LINES-1:0] active_d;
  logic [N_LINES-1:0] active_q;
  logic               req_d;
  logic [VW-1:0]      vec_d;
  logic               nmi_d;

  irq_reg_window #(
    .N_LINES (N_LINES),
    .DW      (DW),
    .AW      (AW)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .bus_err   (bus_err),
    .mask_d    (mask_d),
    .mask_q    (mask_q),
    .raw_q     (raw_q)
  );

  // Next-state gating so the outputs line up with the status registers
  always_comb begin
    active_d = irq_lines & mask_d;
    active_q = raw_q & mask_q;
    nmi_d    = |nmi_lines;
  end

  irq_vec_encoder #(
    .N_LINES (N_LINES),
    .VW      (VW)
  ) u_encoder (
    .active (active_d),
    .req    (req_d),
    .vec    (vec_d)
  );

  // Output registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req   <= 1'b0;
      irq_vec   <= '0;
      nmi_req   <= 1'b0;
      fatal_err <= 1'b0;
    end else begin
      irq_req   <= req_d;
      irq_vec   <= vec_d;
      nmi_req   <= nmi_d;
      fatal_err <= fatal_line;
    end
  end

  assert_idle_vec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q == '0) |-> (!irq_req && (irq_vec == '0)));

  assert_single_vec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(active_q) == 1) |->
      (irq_req && (irq_vec >= VW'(VEC_BASE)) && (irq_vec < VW'(VEC_BASE) + VW'(N_LINES))));

  assert_shared_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(active_q) > 1) |-> (irq_req && (irq_vec == VW'(VEC_SHARED))));

  assert_nmi_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (nmi_req == $past(|nmi_lines)));

  assert_fatal_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fatal_err == $past(fatal_line)));

endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 30;
  localparam logic [31:0] FULL = (32'h1 << NL) - 32'h1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [NL-1:0] irq_lines;
  logic [1:0]  nmi_lines;
  logic        fatal_line;
  logic        bus_sel;
  logic        bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic        nmi_req;
  logic        fatal_err;

  int n_total = 0;
  int n_bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .nmi_lines(nmi_lines),
    .fatal_line(fatal_line), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq_req(irq_req), .irq_vec(irq_vec),
    .nmi_req(nmi_req), .fatal_err(fatal_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected vector: zero, 0x31+i for a lone bit, 0x30 for several
  function automatic logic [7:0] exp_vec(input logic [31:0] act);
    int cnt = 0;
    int pos = 0;
    for (int k = 0; k < NL; k++) if (act[k]) begin cnt++; pos = k; end
    if (cnt == 0) return 8'h00;
    if (cnt == 1) return 8'h31 + 8'(pos);
    return 8'h30;
  endfunction

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d, output logic e);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata; e = bus_err;
    bus_sel = 1'b0;
  endtask

  task automatic apply_lines(input logic [31:0] v, input logic [31:0] m, input string tag);
    @(negedge clk);
    irq_lines = v[NL-1:0];
    @(negedge clk);
    check({tag, " vec"}, {24'h0, irq_vec}, {24'h0, exp_vec(v & m)});
    check({tag, " req"}, {31'h0, irq_req}, {31'h0, ((v & m & FULL) != 0)});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    logic [7:0]  prev;
    rst_n = 1'b0; irq_lines = '0; nmi_lines = '0; fatal_line = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    irq_lines = '1; nmi_lines = 2'b11; fatal_line = 1'b1;
    @(negedge clk);
    // R11: outputs held at zero during reset
    check("R11 req", {31'h0, irq_req}, 32'h0);
    check("R11 vec", {24'h0, irq_vec}, 32'h0);
    check("R11 nmi", {31'h0, nmi_req}, 32'h0);
    check("R11 fatal", {31'h0, fatal_err}, 32'h0);
    irq_lines = '0; nmi_lines = '0; fatal_line = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    bus_read(5'h00, rd, er);
    check("R11 mask", rd, 32'h0);
    check("R2 err", {31'h0, er}, 32'h0);

    // R1 / R2: raw follows lines, masked gated by zero mask
    apply_lines(32'h2A5A_5A5A, 32'h0, "R3 masked off");
    bus_read(5'h04, rd, er);
    check("R1 raw", rd, 32'h2A5A_5A5A & FULL);
    check("R1 err", {31'h0, er}, 32'h0);
    bus_read(5'h08, rd, er);
    check("R2 masked zero", rd, 32'h0);

    bus_write(5'h00, 32'hFFFF_FFFF);
    bus_read(5'h00, rd, er);
    check("R2 mask upper bits", rd, FULL);

    // R3/R4/R5: no line, every single line, every pair
    apply_lines(32'h0, FULL, "R3 idle");
    for (int i = 0; i < NL; i++) begin
      apply_lines(32'h1 << i, FULL, "R4 single");
      bus_read(5'h08, rd, er);
      check("R2 masked single", rd, 32'h1 << i);
    end
    for (int i = 0; i < NL; i++)
      for (int j = i + 1; j < NL; j++)
        apply_lines((32'h1 << i) | (32'h1 << j), FULL, "R5 pair");

    // Single-bit and two-bit masks with all lines high
    irq_lines = '1;
    for (int k = 0; k < NL; k++) begin
      bus_write(5'h00, 32'h1 << k);
      check("R4 mask walk vec", {24'h0, irq_vec}, {24'h0, 8'h31 + 8'(k)});
      bus_read(5'h08, rd, er);
      check("R2 masked walk", rd, 32'h1 << k);
    end
    for (int k = 0; k + 1 < NL; k++) begin
      bus_write(5'h00, 32'h3 << k);
      check("R5 mask pair vec", {24'h0, irq_vec}, 32'h30);
    end

    // R6: change is not visible before the next edge
    bus_write(5'h00, FULL);
    apply_lines(32'h0, FULL, "R3 cleared");
    @(negedge clk);
    prev = irq_vec;
    irq_lines = NL'(32'h1 << 7);
    #1;
    check("R6 before edge", {24'h0, irq_vec}, {24'h0, prev});
    @(negedge clk);
    check("R6 after edge", {24'h0, irq_vec}, 32'h38);

    // R7: writes to read-only offsets ignored
    bus_write(5'h04, 32'h0);
    bus_write(5'h08, 32'h0);
    bus_read(5'h00, rd, er);
    check("R7 mask kept", rd, FULL);
    bus_read(5'h04, rd, er);
    check("R7 raw kept", rd, 32'h80);
    check("R7 vec kept", {24'h0, irq_vec}, 32'h38);

    // R8: undefined and misaligned offsets
    foreach (rd[b]) ; // no-op placeholder loop avoided below
    for (int a = 0; a < 32; a++) begin
      logic exp_err;
      exp_err = (a[1:0] != 2'b00) || (a >= 12);
      bus_read(5'(a), rd, er);
      check("R8 err flag", {31'h0, er}, {31'h0, exp_err});
      if (exp_err) check("R8 reads zero", rd, 32'h0);
      if (exp_err) bus_write(5'(a), 32'h0);
    end
    bus_read(5'h00, rd, er);
    check("R8 mask untouched", rd, FULL);

    // R9: NMI ignores the mask
    bus_write(5'h00, 32'h0);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      nmi_lines = 2'(n);
      @(negedge clk);
      check("R9 nmi", {31'h0, nmi_req}, {31'h0, (n != 0)});
    end
    nmi_lines = '0;

    // R10: fatal line registered
    @(negedge clk);
    fatal_line = 1'b1;
    #1;
    check("R10 before edge", {31'h0, fatal_err}, 32'h0);
    @(negedge clk);
    check("R10 raised", {31'h0, fatal_err}, 32'h1);
    fatal_line = 1'b0;
    @(negedge clk);
    check("R10 cleared", {31'h0, fatal_err}, 32'h0);

    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end

endmodule